// File: doc/BRIEF.md
# Frozen-Gated Event Counter Box

A small performance-monitoring block holding four identical event counters. Each counter is 48 bits wide and is steered by its own 32-bit control word. That word holds an event-select field, which picks one line of the `evt_in` vector, and an enable bit. In any cycle where its enable is set, the box is not frozen and its selected line is high, the counter adds one. Past its largest value it wraps to zero.

One box-wide control word gates every counter at once. Its freeze-enable bit arms the box. Once the box is armed, either the external `frz_in` pin or a stored manual-freeze bit halts all counting. The same word has two write-only pulse bits. One clears every counter value and the other clears every control word.

Software uses a plain register port with byte offsets in an 8-bit address space. Writes are synchronous and reads are combinational. Software can preload either 32-bit half of any counter. The event vector and the freeze pin are sampled every cycle with no handshake, because they carry level information and not a data stream. No input or output of this block can apply back-pressure.

Top module: `evtctr_box`

## Requirements
- R1: After reset every counter value, every control word and the box control word read as zero.
- R2: Control words for counters 0..3 sit at offsets 0xD8, 0xDC, 0xE0 and 0xE4 and read back all 32 written bits. The low and high halves of counter i sit at 0xA0+8i and 0xA4+8i. Box control sits at 0xF4. Every other 8-bit address reads as zero.
- R3: A counter adds exactly one per cycle when control bit 22 is 1, the box is not frozen and `evt_in[sel]` is 1, where sel is control bits 7:0. A sel of 16 or more never counts.
- R4: A counter whose control bit 22 is 0 never changes on events, whatever the other control bits hold.
- R5: With box bit 16 (freeze-enable) set to 1, a high `frz_in` stops all counters. With bit 16 at 0, `frz_in` has no effect.
- R6: Box bit 8 (manual freeze) stops all counters only while box bit 16 is also 1.
- R7: A read of box control returns the stored bits 16 and 8 and zero in every other position, including the two pulse bits.
- R8: Writing box control with bit 1 set clears all four counters at that clock edge. This clear wins over an event in the same cycle.
- R9: Writing box control with bit 0 set clears all four control words and leaves the counter values unchanged.
- R10: A write to a low half replaces bits 31:0 of the counter. A write to a high half replaces bits 47:32 from write-data bits 15:0. The high half reads back as those 16 bits zero-extended.
- R11: A counter at 2^48-1 wraps to 0 on its next increment. A carry out of bit 31 reaches bit 32.
- R12: A write to either half of a counter wins over an event in the same cycle, so that cycle's increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 16 | Per-cycle event lines, indexed by the select field |
| frz_in | input | 1 | External freeze request |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |

## Verification
The counting path is swept over every select value from 0 to 17 on each counter in turn. The sweep uses two complementary event patterns, so a misrouted select, a wrong counter slot or a missing out-of-range guard each yield a different count. The freeze path is tried on all eight combinations of freeze-enable, manual freeze and the external pin, which separates the arming gate from the two freeze sources. Same-cycle collisions of an event with a counter clear and with each preload half, the two wrap boundaries, and a read over all 256 addresses complete the set.

// File: rtl/evtctr_pkg.sv
package evtctr_pkg;
  // Address map (byte offsets); counter i halves at CNT_BASE + 8*i (+4 high),
  // control word i at CTL_BASE + 4*i.
  localparam logic [7:0] CNT_BASE = 8'hA0;
  localparam logic [7:0] CTL_BASE = 8'hD8;
  localparam logic [7:0] BOX_OFF  = 8'hF4;

  // Box control fields
  localparam int BOX_FRZEN_BIT  = 16;
  localparam int BOX_MFRZ_BIT   = 8;
  localparam int BOX_CLRCNT_BIT = 1;
  localparam int BOX_CLRCTL_BIT = 0;

  // Counter control fields
  localparam int CTL_EN_BIT = 22;
  localparam int SEL_W      = 8;

  // Write strobes produced by the box-control stage
  typedef struct packed {
    logic clr_cnt;
    logic clr_ctl;
  } box_pulse_t;
endpackage

// File: rtl/evtctr_regdec.sv
module evtctr_regdec
  import evtctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               box_hit,
  output logic [NUM_CTR-1:0] ctl_hit,
  output logic [NUM_CTR-1:0] lo_hit,
  output logic [NUM_CTR-1:0] hi_hit
);
  assign box_hit = (addr == ADDR_W'(BOX_OFF));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
    localparam int LO_OFF  = int'(CNT_BASE) + 8 * i;
    localparam int HI_OFF  = LO_OFF + 4;
    localparam int CTL_OFF = int'(CTL_BASE) + 4 * i;
    assign lo_hit[i]  = (addr == ADDR_W'(LO_OFF));
    assign hi_hit[i]  = (addr == ADDR_W'(HI_OFF));
    assign ctl_hit[i] = (addr == ADDR_W'(CTL_OFF));
  end
endmodule

// File: rtl/evtctr_freeze.sv
module evtctr_freeze
  import evtctr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       box_wr,
  input  logic       wr_frz_en,
  input  logic       wr_mfrz,
  input  logic       wr_clr_cnt,
  input  logic       wr_clr_ctl,
  input  logic       frz_in,
  output logic       frz_en_q,
  output logic       mfrz_q,
  output logic       frozen,
  output box_pulse_t pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_en_q <= 1'b0;
      mfrz_q   <= 1'b0;
    end else if (box_wr) begin
      frz_en_q <= wr_frz_en;
      mfrz_q   <= wr_mfrz;
    end
  end

  // Pulse bits are never stored: they act at the edge that takes the write.
  assign pulse.clr_cnt = box_wr & wr_clr_cnt;
  assign pulse.clr_ctl = box_wr & wr_clr_ctl;

  // Both freeze sources are gated by the arming bit.
  assign frozen = frz_en_q & (frz_in | mfrz_q);
endmodule

// File: rtl/evtctr_slot.sv
module evtctr_slot
  import evtctr_pkg::*;
#(
  parameter int CTR_W  = 48,
  parameter int EVT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt,
  input  logic              frozen,
  input  box_pulse_t        pulse,
  input  logic              ctl_wr,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic [CTR_W-1:0]  cnt_q
);
  localparam int HI_W = CTR_W - DATA_W;

  logic             evt_sel;
  logic             bump;
  logic [SEL_W-1:0] sel;

  assign sel = ctl_q[SEL_W-1:0];

  // Select mux; any select value at or above EVT_W picks nothing.
  always_comb begin
    evt_sel = 1'b0;
    for (int i = 0; i < EVT_W; i++) begin
      if (sel == SEL_W'(i)) evt_sel = evt[i];
    end
  end

  assign bump = ctl_q[CTL_EN_BIT] & ~frozen & evt_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ctl_q <= '0;
    else if (pulse.clr_ctl) ctl_q <= '0;
    else if (ctl_wr)        ctl_q <= wdata;
  end

  // Priority: clear, then software preload, then increment.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (pulse.clr_cnt) cnt_q <= '0;
    else if (lo_wr)         cnt_q[DATA_W-1:0] <= wdata;
    else if (hi_wr)         cnt_q[CTR_W-1:DATA_W] <= wdata[HI_W-1:0];
    else if (bump)          cnt_q <= cnt_q + CTR_W'(1);
  end
endmodule

// File: rtl/evtctr_box.sv
module evtctr_box
  import evtctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int EVT_W   = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              frz_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic                              box_hit;
  logic [NUM_CTR-1:0]                ctl_hit, lo_hit, hi_hit;
  logic                              frz_en_q, mfrz_q, box_frozen;
  box_pulse_t                        pulse;
  logic [NUM_CTR-1:0][DATA_W-1:0]    ctl_q;
  logic [NUM_CTR-1:0][CTR_W-1:0]     cnt_q;

  evtctr_regdec #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_dec (
    .addr    (reg_addr),
    .box_hit (box_hit),
    .ctl_hit (ctl_hit),
    .lo_hit  (lo_hit),
    .hi_hit  (hi_hit)
  );

  evtctr_freeze u_frz (
    .clk        (clk),
    .rst_n      (rst_n),
    .box_wr     (reg_we & box_hit),
    .wr_frz_en  (reg_wdata[BOX_FRZEN_BIT]),
    .wr_mfrz    (reg_wdata[BOX_MFRZ_BIT]),
    .wr_clr_cnt (reg_wdata[BOX_CLRCNT_BIT]),
    .wr_clr_ctl (reg_wdata[BOX_CLRCTL_BIT]),
    .frz_in     (frz_in),
    .frz_en_q   (frz_en_q),
    .mfrz_q     (mfrz_q),
    .frozen     (box_frozen),
    .pulse      (pulse)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    evtctr_slot #(.CTR_W(CTR_W), .EVT_W(EVT_W), .DATA_W(DATA_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_in),
      .frozen (box_frozen),
      .pulse  (pulse),
      .ctl_wr (reg_we & ctl_hit[i]),
      .lo_wr  (reg_we & lo_hit[i]),
      .hi_wr  (reg_we & hi_hit[i]),
      .wdata  (reg_wdata),
      .ctl_q  (ctl_q[i]),
      .cnt_q  (cnt_q[i])
    );
  end

  // Read mux: address hits are mutually exclusive; unmapped reads give zero.
  always_comb begin
    reg_rdata = '0;
    if (box_hit) begin
      reg_rdata[BOX_FRZEN_BIT] = frz_en_q;
      reg_rdata[BOX_MFRZ_BIT]  = mfrz_q;
    end
    for (int i = 0; i < NUM_CTR; i++) begin
      if (ctl_hit[i]) reg_rdata = ctl_q[i];
      if (lo_hit[i])  reg_rdata = cnt_q[i][DATA_W-1:0];
      if (hi_hit[i])  reg_rdata = DATA_W'(cnt_q[i][CTR_W-1:DATA_W]);
    end
  end
endmodule

// File: rtl/evtctr_box_chk.sv
module evtctr_box_chk
  import evtctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic                           reg_we,
  input logic [1:0]                     wr_pulses,
  input logic [DATA_W-1:0]              reg_rdata,
  input logic                           frz_en_q,
  input logic                           box_frozen,
  input logic [NUM_CTR-1:0][DATA_W-1:0] ctl_q,
  input logic [NUM_CTR-1:0][CTR_W-1:0]  cnt_q
);
  logic mapped;
  always_comb begin
    mapped = (reg_addr == ADDR_W'(BOX_OFF));
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == ADDR_W'(int'(CTL_BASE) + 4 * i)) mapped = 1'b1;
      if (reg_addr == ADDR_W'(int'(CNT_BASE) + 8 * i)) mapped = 1'b1;
      if (reg_addr == ADDR_W'(int'(CNT_BASE) + 8 * i + 4)) mapped = 1'b1;
    end
  end

  logic box_wr;
  assign box_wr = reg_we && (reg_addr == ADDR_W'(BOX_OFF));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == '0);

  p_box_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(BOX_OFF)) |->
      (reg_rdata & ~((DATA_W'(1) << BOX_FRZEN_BIT) | (DATA_W'(1) << BOX_MFRZ_BIT))) == '0);

  p_unarmed_no_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_en_q |-> !box_frozen);

  p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (box_frozen && !reg_we) |=> $stable(cnt_q));

  p_clear_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (box_wr && wr_pulses[BOX_CLRCNT_BIT]) |=> cnt_q == '0);

  p_clear_ctls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (box_wr && wr_pulses[BOX_CLRCTL_BIT]) |=> ctl_q == '0);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_step
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> (cnt_q[i] == $past(cnt_q[i]) ||
                   cnt_q[i] == $past(cnt_q[i]) + CTR_W'(1)));
  end
endmodule

bind evtctr_box evtctr_box_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_we     (reg_we),
  .wr_pulses  (reg_wdata[1:0]),
  .reg_rdata  (reg_rdata),
  .frz_en_q   (frz_en_q),
  .box_frozen (box_frozen),
  .ctl_q      (ctl_q),
  .cnt_q      (cnt_q)
);

// File: tb/tb_evtctr_box.sv
module tb_evtctr_box;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_in = '0;
  logic        frz_in = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] EN = 32'h0040_0000;  // control bit 22

  evtctr_box dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .frz_in(frz_in),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  // Write while events are high during that single cycle.
  task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [15:0] e);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; evt_in = e;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; evt_in = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_cnt(input int i, output logic [47:0] v);
    logic [31:0] lo, hi;
    rd(8'(8'hA0 + 8 * i), lo);
    rd(8'(8'hA4 + 8 * i), hi);
    v = {hi[15:0], lo};
    chk($sformatf("R10 hi-zero-ext c%0d", i), {32'd0, hi[31:16]}, 64'd0);
  endtask

  // n rising edges with events e and freeze pin f applied.
  task automatic run(input logic [15:0] e, input logic f, input int n);
    @(negedge clk);
    evt_in = e; frz_in = f;
    repeat (n) @(negedge clk);
    evt_in = '0; frz_in = 1'b0;
  endtask

  function automatic bit is_mapped(input int a);
    if (a == 'hF4) return 1;
    for (int i = 0; i < 4; i++)
      if (a == 'hD8 + 4 * i || a == 'hA0 + 8 * i || a == 'hA4 + 8 * i) return 1;
    return 0;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [47:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_cnt(i, v); chk($sformatf("R1 cnt%0d", i), {16'd0, v}, 64'd0);
      rd(8'(8'hD8 + 4 * i), d); chk($sformatf("R1 ctl%0d", i), {32'd0, d}, 64'd0);
    end
    rd(8'hF4, d); chk("R1 box", {32'd0, d}, 64'd0);

    // R3/R4: select sweep on every counter with two complementary patterns
    for (int p = 0; p < 2; p++) begin
      logic [15:0] pat;
      pat = (p == 0) ? 16'hA5C3 : 16'h5A3C;
      for (int sel = 0; sel < 18; sel++) begin
        int c;
        c = sel % 4;
        wr(8'hF4, 32'h1);
        wr(8'(8'hD8 + 4 * c), EN | 32'(sel));
        wr(8'hF4, 32'h2);
        run(pat, 1'b0, 3);
        for (int k = 0; k < 4; k++) begin
          logic [47:0] ex;
          ex = (k == c && sel < 16 && pat[sel % 16]) ? 48'd3 : 48'd0;
          rd_cnt(k, v);
          chk($sformatf("R3 sel=%0d pat=%0d c%0d", sel, p, k), {16'd0, v}, {16'd0, ex});
        end
      end
    end

    // R4: enable clear, every other control bit set
    wr(8'hF4, 32'h3);
    wr(8'hD8, 32'hFFBF_FF00);
    run(16'hFFFF, 1'b0, 4);
    rd_cnt(0, v); chk("R4 disabled", {16'd0, v}, 64'd0);

    // R5/R6/R7: freeze truth table
    wr(8'hD8, EN);
    for (int m = 0; m < 8; m++) begin
      bit en, mf, fi;
      en = m[2]; mf = m[1]; fi = m[0];
      wr(8'hF4, (32'(en) << 16) | (32'(mf) << 8) | 32'h2);
      run(16'h0001, fi, 5);
      rd_cnt(0, v);
      if (mf) chk($sformatf("R6 en=%0d in=%0d", en, fi), {16'd0, v},
                  (en && (mf || fi)) ? 64'd0 : 64'd5);
      else    chk($sformatf("R5 en=%0d in=%0d", en, fi), {16'd0, v},
                  (en && (mf || fi)) ? 64'd0 : 64'd5);
      rd(8'hF4, d);
      chk($sformatf("R7 box m=%0d", m), {32'd0, d}, {32'd0, (32'(en) << 16) | (32'(mf) << 8)});
    end
    wr(8'hF4, 32'h0000_0103);
    rd(8'hF4, d); chk("R7 pulses read zero", {32'd0, d}, 64'h100);
    wr(8'hF4, 32'h0);

    // R8: clear beats same-cycle event
    wr(8'hD8, EN);
    wr(8'hA0, 32'd10);
    wr_evt(8'hF4, 32'h2, 16'hFFFF);
    rd_cnt(0, v); chk("R8 clear wins", {16'd0, v}, 64'd0);

    // R12: preload beats same-cycle event, each half
    wr_evt(8'hA0, 32'd100, 16'hFFFF);
    rd_cnt(0, v); chk("R12 low write wins", {16'd0, v}, 64'd100);
    wr_evt(8'hA4, 32'd7, 16'hFFFF);
    rd_cnt(0, v); chk("R12 high write wins", {16'd0, v}, {16'd0, 16'd7, 32'd100});

    // R10: half preloads and zero extension
    wr(8'hA8, 32'hDEAD_BEEF);
    wr(8'hAC, 32'hFFFF_1234);
    rd(8'hA8, d); chk("R10 lo", {32'd0, d}, 64'hDEAD_BEEF);
    rd(8'hAC, d); chk("R10 hi", {32'd0, d}, 64'h1234);

    // R9: control clear leaves counters
    for (int i = 0; i < 4; i++) wr(8'(8'hD8 + 4 * i), EN | 32'h0F00_0000);
    wr(8'hF4, 32'h1);
    for (int i = 0; i < 4; i++) begin
      rd(8'(8'hD8 + 4 * i), d); chk($sformatf("R9 ctl%0d", i), {32'd0, d}, 64'd0);
    end
    rd_cnt(0, v); chk("R9 cnt kept", {16'd0, v}, {16'd0, 16'd7, 32'd100});

    // R11: wrap and carry
    wr(8'hE4, EN | 32'd5);
    wr(8'hBC, 32'h0000_FFFF);
    wr(8'hB8, 32'hFFFF_FFFF);
    run(16'h0020, 1'b0, 1);
    rd_cnt(3, v); chk("R11 wrap", {16'd0, v}, 64'd0);
    wr(8'hB8, 32'hFFFF_FFFF);
    run(16'h0020, 1'b0, 1);
    rd_cnt(3, v); chk("R11 carry", {16'd0, v}, 64'h1_0000_0000);

    // R2: control readback and full address sweep
    wr(8'hF4, 32'h3);
    for (int i = 0; i < 4; i++) wr(8'(8'hD8 + 4 * i), 32'h9000_0000 | 32'(i * 32'h1111));
    for (int i = 0; i < 4; i++) begin
      rd(8'(8'hD8 + 4 * i), d);
      chk($sformatf("R2 ctl%0d", i), {32'd0, d}, {32'd0, 32'h9000_0000 | 32'(i * 32'h1111)});
    end
    wr(8'hA0, 32'hFFFF_FFFF);
    wr(8'hF4, 32'h0001_0100);
    for (int a = 0; a < 256; a++) begin
      if (!is_mapped(a)) begin
        rd(8'(a), d); chk($sformatf("R2 unmapped %02h", a), {32'd0, d}, 64'd0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule